// File: doc/BRIEF.md
# USB Device Endpoint Event and Request Register Bank

This block is the software-visible register bank for the endpoint bookkeeping of a USB device controller with twelve endpoints in each direction. Software reads and writes seven 32-bit registers through a simple write-enable, address and data port with a combinational read path. The controller core reports NAKs it sent, SETUP packets it received and transfers it finished. It also acknowledges prime and flush requests. The bank turns software writes into prime and flush request vectors for the core, and it raises a single NAK interrupt.

Internally each per-endpoint vector has 24 bits. Bit `i` (0..11) is receive endpoint `i` and bit `12+i` is transmit endpoint `i`. In every 32-bit register word, receive endpoints sit in bits 11:0 and transmit endpoints in bits 27:16. Bits 31:28 and 15:12 are unused. The register index is taken from `sw_addr`: 0 NAK flags, 1 NAK enables, 2 SETUP flags, 3 prime requests, 4 flush requests, 5 primed status, 6 completion flags. Index 7 reads zero.

Top module: `usb_ep_regbank`

## Requirements
- R1: After reset every register reads zero, and `prime_req`, `flush_req` and `nak_irq` are low.
- R2: Each register word maps receive endpoint i to bit i and transmit endpoint i to bit 16+i. Bits 31:28 and 15:12 of every register always read zero and ignore writes. Bits 31:12 of the SETUP register (index 2) and all bits of index 7 read zero.
- R3: The NAK register (index 0) sets a bit on the matching `evt_nak` pulse. Writing one to a bit clears it, and writing zero leaves it unchanged.
- R4: The NAK-enable register (index 1) is plain read/write and holds the last value written to its valid bits.
- R5: The SETUP register (index 2) sets receive bit i on `evt_setup[i]`. Writing one clears the bit.
- R6: The prime register (index 3) is write-one-to-set, and a written zero has no effect. Its contents drive `prime_req`, with the same 24-bit vector layout.
- R7: A `prime_ack` bit clears that prime bit and sets that primed-status bit in the same edge. A software write-one to the same prime bit in that cycle keeps the request set.
- R8: The flush register (index 4) is write-one-to-set and drives `flush_req`. A `flush_ack` bit clears that flush bit and that status bit. A software write-one in the same cycle keeps the flush request set. A flush acknowledgement beats a prime acknowledgement on the status bit.
- R9: The primed-status register (index 5) is read-only, and writes to it change nothing.
- R10: The completion register (index 6) sets a bit on the matching `evt_cmpl` pulse. Writing one clears it.
- R11: When a hardware set event and a software write-one-to-clear hit the same bit in one cycle, the bit ends set.
- R12: `nak_irq` equals, one clock later, the OR over all endpoints of the NAK bit ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 3 | Register index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data for `sw_addr` (combinational) |
| evt_nak | input | 24 | NAK sent, per endpoint vector bit |
| evt_setup | input | 12 | SETUP received, receive endpoints |
| evt_cmpl | input | 24 | Primed transfer finished |
| prime_ack | input | 24 | Core accepted the prime |
| flush_ack | input | 24 | Core finished the flush |
| prime_req | output | 24 | Pending prime requests |
| flush_req | output | 24 | Pending flush requests |
| nak_irq | output | 1 | Registered NAK interrupt |

## Verification
The collisions that matter are a hardware event meeting a software write on the same bit in one cycle. There are three cases: a NAK, SETUP or completion event against a write-one-to-clear, a prime or flush acknowledgement against a fresh write-one-to-set, and a prime acknowledgement against a flush acknowledgement on the status bit. Directed steps force each of these pairs on a single bit. Dense random events, mixed with random full-word writes, then produce the pairs many times over. After every step all eight register indices and the request outputs are compared with a bench model built from the requirements.

// File: rtl/ep_regs_pkg.sv
package ep_regs_pkg;
    typedef enum logic [2:0] {
        REG_NAK    = 3'd0,
        REG_NAKEN  = 3'd1,
        REG_SETUP  = 3'd2,
        REG_PRIME  = 3'd3,
        REG_FLUSH  = 3'd4,
        REG_STATUS = 3'd5,
        REG_CMPL   = 3'd6
    } ep_reg_e;
endpackage

// File: rtl/ep_w1c_bank.sv
module ep_w1c_bank #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_clr,
    output logic [W-1:0] bits_q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~sw_clr) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((bits_q & $past(hw_set)) == $past(hw_set)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~hw_set)) |=> ((bits_q & $past(sw_clr & ~hw_set)) == '0));
endmodule

// File: rtl/ep_req_bank.sv
module ep_req_bank #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] hw_ack,
    output logic [W-1:0] bits_q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits & ~hw_ack) | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    assert_req_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_set) |=> ((bits_q & $past(sw_set)) == $past(sw_set)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_ack & ~sw_set)) |=> ((bits_q & $past(hw_ack & ~sw_set)) == '0));
endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] primed,
    input  logic [W-1:0] flushed,
    output logic [W-1:0] bits_q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits = (st_q.bits | primed) & ~flushed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_q = st_q.bits;

    assert_status_on_prime_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(primed & ~flushed)) |=> ((bits_q & $past(primed & ~flushed)) == $past(primed & ~flushed)));

    assert_status_off_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flushed) |=> ((bits_q & $past(flushed)) == '0));
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         irq_q
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.irq = |(flags & enables);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_q = st_q.irq;

    assert_irq_lags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == $past(|(flags & enables)));
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
    import ep_regs_pkg::*;
#(
    parameter int NUM_EP  = 12,
    parameter int TX_BASE = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_we,
    input  logic [ADDR_W-1:0]     sw_addr,
    input  logic [DATA_W-1:0]     sw_wdata,
    output logic [DATA_W-1:0]     sw_rdata,
    input  logic [2*NUM_EP-1:0]   evt_nak,
    input  logic [NUM_EP-1:0]     evt_setup,
    input  logic [2*NUM_EP-1:0]   evt_cmpl,
    input  logic [2*NUM_EP-1:0]   prime_ack,
    input  logic [2*NUM_EP-1:0]   flush_ack,
    output logic [2*NUM_EP-1:0]   prime_req,
    output logic [2*NUM_EP-1:0]   flush_req,
    output logic                  nak_irq
);
    localparam int VW = 2 * NUM_EP;
    localparam logic [DATA_W-1:0] RX_MASK = DATA_W'((64'd1 << NUM_EP) - 64'd1);
    localparam logic [DATA_W-1:0] VALID_MASK = RX_MASK | (RX_MASK << TX_BASE);

    function automatic logic [VW-1:0] word_to_vec(input logic [DATA_W-1:0] w);
        return {w[TX_BASE +: NUM_EP], w[NUM_EP-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] vec_to_word(input logic [VW-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[NUM_EP-1:0]       = v[NUM_EP-1:0];
        w[TX_BASE +: NUM_EP] = v[VW-1:NUM_EP];
        return w;
    endfunction

    function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a, input ep_reg_e r);
        return we && (a == ADDR_W'(r));
    endfunction

    typedef struct packed {
        logic [VW-1:0] naken;
    } state_t;

    state_t st_d, st_q;

    logic [VW-1:0]     wvec;
    logic [VW-1:0]     nak_clr, cmpl_clr, prime_set, flush_set;
    logic [NUM_EP-1:0] setup_clr;
    logic [VW-1:0]     nak_q, cmpl_q, status_q;
    logic [NUM_EP-1:0] setup_q;
    logic              unused_wbits;

    assign unused_wbits = ^(sw_wdata & ~VALID_MASK);

    always_comb begin
        wvec      = word_to_vec(sw_wdata);
        nak_clr   = hit(sw_we, sw_addr, REG_NAK)   ? wvec : '0;
        cmpl_clr  = hit(sw_we, sw_addr, REG_CMPL)  ? wvec : '0;
        prime_set = hit(sw_we, sw_addr, REG_PRIME) ? wvec : '0;
        flush_set = hit(sw_we, sw_addr, REG_FLUSH) ? wvec : '0;
        setup_clr = hit(sw_we, sw_addr, REG_SETUP) ? sw_wdata[NUM_EP-1:0] : '0;
        st_d = st_q;
        if (hit(sw_we, sw_addr, REG_NAKEN)) st_d.naken = wvec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ep_w1c_bank #(.W(VW)) u_nak (
        .clk(clk), .rst_n(rst_n), .hw_set(evt_nak), .sw_clr(nak_clr), .bits_q(nak_q));

    ep_w1c_bank #(.W(NUM_EP)) u_setup (
        .clk(clk), .rst_n(rst_n), .hw_set(evt_setup), .sw_clr(setup_clr), .bits_q(setup_q));

    ep_w1c_bank #(.W(VW)) u_cmpl (
        .clk(clk), .rst_n(rst_n), .hw_set(evt_cmpl), .sw_clr(cmpl_clr), .bits_q(cmpl_q));

    ep_req_bank #(.W(VW)) u_prime (
        .clk(clk), .rst_n(rst_n), .sw_set(prime_set), .hw_ack(prime_ack), .bits_q(prime_req));

    ep_req_bank #(.W(VW)) u_flush (
        .clk(clk), .rst_n(rst_n), .sw_set(flush_set), .hw_ack(flush_ack), .bits_q(flush_req));

    ep_status_bank #(.W(VW)) u_status (
        .clk(clk), .rst_n(rst_n), .primed(prime_ack), .flushed(flush_ack), .bits_q(status_q));

    ep_irq_gen #(.W(VW)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(nak_q), .enables(st_q.naken), .irq_q(nak_irq));

    always_comb begin
        sw_rdata = '0;
        case (sw_addr)
            ADDR_W'(REG_NAK):    sw_rdata = vec_to_word(nak_q);
            ADDR_W'(REG_NAKEN):  sw_rdata = vec_to_word(st_q.naken);
            ADDR_W'(REG_SETUP):  sw_rdata[NUM_EP-1:0] = setup_q;
            ADDR_W'(REG_PRIME):  sw_rdata = vec_to_word(prime_req);
            ADDR_W'(REG_FLUSH):  sw_rdata = vec_to_word(flush_req);
            ADDR_W'(REG_STATUS): sw_rdata = vec_to_word(status_q);
            ADDR_W'(REG_CMPL):   sw_rdata = vec_to_word(cmpl_q);
            default:             sw_rdata = '0;
        endcase
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata & ~VALID_MASK) == '0);

    assert_naken_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit(sw_we, sw_addr, REG_NAKEN) |=> $stable(st_q.naken));
endmodule

// File: tb/tb_usb_ep_regbank.sv
module tb_usb_ep_regbank;
    localparam int N  = 12;
    localparam int VW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_we = 1'b0;
    logic [2:0]    sw_addr = '0;
    logic [31:0]   sw_wdata = '0;
    logic [31:0]   sw_rdata;
    logic [VW-1:0] evt_nak = '0, evt_cmpl = '0, prime_ack = '0, flush_ack = '0;
    logic [N-1:0]  evt_setup = '0;
    logic [VW-1:0] prime_req, flush_req;
    logic          nak_irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [VW-1:0] m_nak, m_en, m_prime, m_flush, m_stat, m_cmpl;
    logic [N-1:0]  m_setup;
    logic          m_irq;

    always #5 clk = ~clk;

    usb_ep_regbank dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .evt_nak(evt_nak), .evt_setup(evt_setup), .evt_cmpl(evt_cmpl),
        .prime_ack(prime_ack), .flush_ack(flush_ack), .prime_req(prime_req),
        .flush_req(flush_req), .nak_irq(nak_irq));

    function automatic logic [VW-1:0] unpack(input logic [31:0] w);
        return {w[27:16], w[11:0]};
    endfunction

    function automatic logic [31:0] pack(input logic [VW-1:0] v);
        return {4'b0, v[23:12], 4'b0, v[11:0]};
    endfunction

    function automatic logic [31:0] exp_word(input int a);
        case (a)
            0: return pack(m_nak);
            1: return pack(m_en);
            2: return {20'b0, m_setup};
            3: return pack(m_prime);
            4: return pack(m_flush);
            5: return pack(m_stat);
            6: return pack(m_cmpl);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string extra);
        for (int a = 0; a < 8; a++) begin
            sw_addr = 3'(a);
            #1;
            check({tag_of(a), extra}, sw_rdata, exp_word(a));
            check("R2", sw_rdata & 32'hF000_F000, 32'h0);
        end
        check({"R6", extra}, 32'(prime_req), 32'(m_prime));
        check({"R8", extra}, 32'(flush_req), 32'(m_flush));
        check({"R12", extra}, 32'(nak_irq), 32'(m_irq));
    endtask

    // One clock: drive at negedge, update model after posedge, read everything back.
    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic [VW-1:0] nk, input logic [N-1:0] su,
                        input logic [VW-1:0] cp, input logic [VW-1:0] pa,
                        input logic [VW-1:0] fa, input string extra);
        logic [VW-1:0] wv;
        @(negedge clk);
        sw_we = we; sw_addr = a; sw_wdata = wd;
        evt_nak = nk; evt_setup = su; evt_cmpl = cp; prime_ack = pa; flush_ack = fa;
        @(posedge clk);
        #1;
        wv    = unpack(wd);
        m_irq = |(m_nak & m_en);
        m_nak   = (m_nak & ~((we && a == 3'd0) ? wv : '0)) | nk;
        if (we && a == 3'd1) m_en = wv;
        m_setup = (m_setup & ~((we && a == 3'd2) ? wd[11:0] : '0)) | su;
        m_prime = (m_prime & ~pa) | ((we && a == 3'd3) ? wv : '0);
        m_flush = (m_flush & ~fa) | ((we && a == 3'd4) ? wv : '0);
        m_stat  = (m_stat | pa) & ~fa;
        m_cmpl  = (m_cmpl & ~((we && a == 3'd6) ? wv : '0)) | cp;
        sw_we = 1'b0; evt_nak = '0; evt_setup = '0; evt_cmpl = '0; prime_ack = '0; flush_ack = '0;
        check_all(extra);
    endtask

    function automatic logic [VW-1:0] sparse(input int k);
        logic [VW-1:0] v = '0;
        for (int i = 0; i < VW; i++) if (($urandom % k) == 0) v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        {m_nak, m_en, m_prime, m_flush, m_stat, m_cmpl} = '0;
        m_setup = '0;
        m_irq = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check_all(" reset R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: reserved bits written, index 7 written
        step(1'b1, 3'd1, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, " reserved R2");
        step(1'b1, 3'd7, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, " idx7 R2");
        // R12: NAK on tx ep 3 with enables set -> irq one clock later
        step(1'b0, 3'd0, 32'h0, 24'h1 << 15, '0, '0, '0, '0, " irq lag R12");
        step(1'b0, 3'd0, 32'h0, '0, '0, '0, '0, '0, " irq up R12");
        // R11: clear of tx ep 3 NAK together with a new NAK event on it
        step(1'b1, 3'd0, 32'h0008_0000, 24'h1 << 15, '0, '0, '0, '0, " set wins R11");
        step(1'b1, 3'd0, 32'h0008_0000, '0, '0, '0, '0, '0, " w1c R3");
        // R5 / R10 collisions
        step(1'b1, 3'd2, 32'h0000_0004, '0, 12'h4, 24'h1 << 5, '0, '0, " setup R11");
        step(1'b1, 3'd6, 32'h0000_0020, '0, '0, 24'h1 << 5, '0, '0, " cmpl R11");
        // R6/R7: prime rx ep 2, ack with simultaneous re-prime, then plain ack
        step(1'b1, 3'd3, 32'h0000_0004, '0, '0, '0, '0, '0, " prime R6");
        step(1'b1, 3'd3, 32'h0000_0004, '0, '0, '0, 24'h4, '0, " reprime R7");
        step(1'b0, 3'd3, 32'h0, '0, '0, '0, 24'h4, '0, " ack R7");
        // R9: status is read-only
        step(1'b1, 3'd5, 32'h0000_0000, '0, '0, '0, '0, '0, " ro R9");
        step(1'b1, 3'd5, 32'hFFFF_FFFF, '0, '0, '0, '0, '0, " ro R9");
        // R8: flush ack and prime ack on the same bit
        step(1'b1, 3'd4, 32'h0000_0004, '0, '0, '0, '0, '0, " flush R8");
        step(1'b1, 3'd4, 32'h0000_0004, '0, '0, '0, 24'h4, 24'h4, " collide R8");
        step(1'b0, 3'd4, 32'h0, '0, '0, '0, '0, 24'h4, " fack R8");

        for (int s = 0; s < 400; s++) begin
            step(($urandom % 4) != 0, 3'($urandom % 8), $urandom,
                 sparse(6), N'(sparse(5)), sparse(6), sparse(4), sparse(7), " rand");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule